// File: doc/BRIEF.md
# Digital Sinusoidal PWM Modulator

This block generates the switching duty bit for a bipolar switched-capacitor inverter. Every cycle it takes a signed sampled sine reference and a signed sampled measurement of the inverter output. It subtracts the measurement from the reference and scales the result through two proportional gains to get a control value, which is clamped to the carrier amplitude. The control value is then compared against a digital triangle carrier. The triangle is used with its own sign while the output is in its positive half-wave and with the opposite sign while it is in its negative half-wave.

The block has two outputs. One is the registered duty bit. The other is a half-wave flag that tells the downstream switch decoder which polarity of topology to drive. The half-wave flag is taken from the reference sign once per carrier period, so the polarity never changes in the middle of a carrier ramp. The carrier is an up/down counter. Its amplitude and its step rate are inputs, so the carrier frequency can follow changes in the reference peak and frequency.

There are two state machines. The carrier machine has the states CAR_RISE and CAR_FALL. It moves from CAR_RISE to CAR_FALL when a step reaches the peak, or when the count already sits at or above the peak. It moves from CAR_FALL to CAR_RISE when a step reaches zero, or when the count already sits at zero. The duty machine has the states DUTY_LOW and DUTY_HIGH. It moves to DUTY_HIGH when the comparison rule for the current half-wave favours the control value, and to DUTY_LOW when the rule goes against it. It stays in its current state when the two compared values are exactly equal.

Top module: `sine_pwm_mod`

## Requirements
- R1: While reset is asserted and after it is released, before the first clock edge: `duty` is 0 and `pos_half` is 1.
- R2: The carrier starts at 0 and rises. It moves one count on every (`step_div`+1)-th clock and goes 0,1,…,`car_peak`,…,1,0,1,… Each end value is held for a single step, so one period is 2·`car_peak`·(`step_div`+1) clocks.
- R3: The tracking error is `ref_smp` − `meas_smp`, computed one bit wider than the inputs so that it never wraps.
- R4: `gain_a` and `gain_b` are unsigned fixed-point values with 4 fraction bits, so 16 means 1.0. The control value is floor(floor(error·`gain_a`/16)·`gain_b`/16).
- R5: The control value is saturated to the range −`car_peak` to +`car_peak` before the comparison.
- R6: `pos_half` is loaded with the inverse of the sign bit of `ref_smp` only on the carrier step that leaves 0 in the rising direction. The first such step is the first step after reset. At all other times `pos_half` holds its value.
- R7: While `pos_half`=1: a control value above the carrier sets the duty bit, and a control value below the carrier clears it.
- R8: While `pos_half`=0: a control value below the negated carrier sets the duty bit, and a control value above it clears it.
- R9: If the control value equals the compared carrier exactly, the duty bit keeps its previous value.
- R10: The duty bit is registered. `duty` shows the result of the comparison made with the carrier value of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_smp | input | DATA_W | Signed sine reference sample |
| meas_smp | input | DATA_W | Signed measured output sample |
| gain_a | input | GAIN_W | First proportional gain, unsigned Q4.4 |
| gain_b | input | GAIN_W | Second proportional gain, unsigned Q4.4 |
| car_peak | input | CAR_W | Carrier amplitude |
| step_div | input | DIV_W | Clocks per carrier step, minus one |
| duty | output | 1 | Registered duty bit |
| pos_half | output | 1 | 1 in the positive half-wave, 0 in the negative |

## Verification
The bench drives the control value exactly to the carrier peak. A design that treats equality as a loss drops the duty bit at the top of every ramp instead of holding it. The bench also saturates the gains with a full-scale error of opposite-signed inputs. An error path that is too narrow wraps and sends the duty bit to the wrong level. To test the polarity hold, the bench flips the reference sign in the middle of a ramp. A design that follows the sign at once changes `pos_half` before the period boundary. The bench also times the rising duty edge against the carrier falling through the control value. An extra or a missing register stage moves that edge by one cycle.

// File: rtl/sine_pwm_pkg.sv
package sine_pwm_pkg;

    typedef enum logic {
        CAR_RISE = 1'b0,
        CAR_FALL = 1'b1
    } car_dir_e;

    typedef enum logic {
        DUTY_LOW  = 1'b0,
        DUTY_HIGH = 1'b1
    } duty_state_e;

endpackage

// File: rtl/sine_pwm_carrier.sv
module sine_pwm_carrier
    import sine_pwm_pkg::*;
#(
    parameter int CAR_W = 11,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAR_W-1:0] car_peak,
    input  logic [DIV_W-1:0] step_div,
    input  logic             ref_sign,
    output logic [CAR_W-1:0] car_val,
    output logic             period_start,
    output logic             pos_half
);

    logic [DIV_W-1:0] presc_q;
    logic             step;
    car_dir_e         dir_q, dir_d;
    logic [CAR_W-1:0] car_q, car_d;
    logic             half_q;

    assign step = (presc_q >= step_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (step) begin
            presc_q <= '0;
        end else begin
            presc_q <= presc_q + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= CAR_RISE;
            car_q <= '0;
        end else begin
            dir_q <= dir_d;
            car_q <= car_d;
        end
    end

    // next-state logic
    always_comb begin
        dir_d = dir_q;
        car_d = car_q;
        if (step) begin
            unique case (dir_q)
                CAR_RISE: begin
                    if (car_q < car_peak) begin
                        car_d = car_q + 1'b1;
                        if (car_q + 1'b1 == car_peak) begin
                            dir_d = CAR_FALL;
                        end
                    end else begin
                        dir_d = CAR_FALL;
                        if (car_q != '0) begin
                            car_d = car_q - 1'b1;
                        end
                    end
                end
                CAR_FALL: begin
                    if (car_q != '0) begin
                        car_d = car_q - 1'b1;
                        if (car_q == CAR_W'(1)) begin
                            dir_d = CAR_RISE;
                        end
                    end else begin
                        dir_d = CAR_RISE;
                    end
                end
                default: begin
                    dir_d = CAR_RISE;
                end
            endcase
        end
    end

    assign period_start = step && (dir_q == CAR_RISE) && (car_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b1;
        end else if (period_start) begin
            half_q <= ~ref_sign;
        end
    end

    // outputs
    always_comb begin
        car_val  = car_q;
        pos_half = half_q;
    end

endmodule

// File: rtl/sine_pwm_comp.sv
module sine_pwm_comp #(
    parameter int DATA_W    = 12,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 4,
    parameter int CAR_W     = 11
) (
    input  logic signed [DATA_W-1:0] ref_smp,
    input  logic signed [DATA_W-1:0] meas_smp,
    input  logic        [GAIN_W-1:0] gain_a,
    input  logic        [GAIN_W-1:0] gain_b,
    input  logic        [CAR_W-1:0]  car_peak,
    output logic signed [CAR_W:0]    ctrl
);

    localparam int ERR_W = DATA_W + 1;
    localparam int P1_W  = ERR_W + GAIN_W + 1;
    localparam int P2_W  = P1_W + GAIN_W + 1;

    logic signed [ERR_W-1:0] err;
    logic signed [P1_W-1:0]  err_x, ga_x, p1_full, p1;
    logic signed [P2_W-1:0]  p1_x, gb_x, p2_full, p2, lim_x;

    assign err     = {ref_smp[DATA_W-1], ref_smp} - {meas_smp[DATA_W-1], meas_smp};
    assign err_x   = P1_W'(err);
    assign ga_x    = {{(P1_W-GAIN_W){1'b0}}, gain_a};
    assign p1_full = err_x * ga_x;
    assign p1      = p1_full >>> GAIN_FRAC;

    assign p1_x    = P2_W'(p1);
    assign gb_x    = {{(P2_W-GAIN_W){1'b0}}, gain_b};
    assign p2_full = p1_x * gb_x;
    assign p2      = p2_full >>> GAIN_FRAC;

    assign lim_x   = {{(P2_W-CAR_W){1'b0}}, car_peak};

    always_comb begin
        if (p2 > lim_x) begin
            ctrl = $signed({1'b0, car_peak});
        end else if (p2 < -lim_x) begin
            ctrl = -$signed({1'b0, car_peak});
        end else begin
            ctrl = p2[CAR_W:0];
        end
    end

endmodule

// File: rtl/sine_pwm_cmp.sv
module sine_pwm_cmp
    import sine_pwm_pkg::*;
#(
    parameter int CAR_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic signed [CAR_W:0] ctrl,
    input  logic [CAR_W-1:0]      car_val,
    input  logic                  pos_half,
    output logic                  duty
);

    duty_state_e         st_q, st_d;
    logic signed [CAR_W:0] car_pos, car_neg;

    assign car_pos = $signed({1'b0, car_val});
    assign car_neg = -car_pos;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DUTY_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (pos_half) begin
            if (ctrl > car_pos) begin
                st_d = DUTY_HIGH;
            end else if (ctrl < car_pos) begin
                st_d = DUTY_LOW;
            end
        end else begin
            if (ctrl < car_neg) begin
                st_d = DUTY_HIGH;
            end else if (ctrl > car_neg) begin
                st_d = DUTY_LOW;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            DUTY_HIGH: duty = 1'b1;
            DUTY_LOW:  duty = 1'b0;
            default:   duty = 1'b0;
        endcase
    end

endmodule

// File: rtl/sine_pwm_mod.sv
module sine_pwm_mod #(
    parameter int DATA_W    = 12,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 4,
    parameter int CAR_W     = DATA_W - 1,
    parameter int DIV_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] ref_smp,
    input  logic signed [DATA_W-1:0] meas_smp,
    input  logic [GAIN_W-1:0]        gain_a,
    input  logic [GAIN_W-1:0]        gain_b,
    input  logic [CAR_W-1:0]         car_peak,
    input  logic [DIV_W-1:0]         step_div,
    output logic                     duty,
    output logic                     pos_half
);

    logic [CAR_W-1:0]      car_val;
    logic                  period_start;
    logic signed [CAR_W:0] ctrl_val;

    sine_pwm_carrier #(
        .CAR_W (CAR_W),
        .DIV_W (DIV_W)
    ) u_carrier (
        .clk          (clk),
        .rst_n        (rst_n),
        .car_peak     (car_peak),
        .step_div     (step_div),
        .ref_sign     (ref_smp[DATA_W-1]),
        .car_val      (car_val),
        .period_start (period_start),
        .pos_half     (pos_half)
    );

    sine_pwm_comp #(
        .DATA_W    (DATA_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .CAR_W     (CAR_W)
    ) u_comp (
        .ref_smp  (ref_smp),
        .meas_smp (meas_smp),
        .gain_a   (gain_a),
        .gain_b   (gain_b),
        .car_peak (car_peak),
        .ctrl     (ctrl_val)
    );

    sine_pwm_cmp #(
        .CAR_W (CAR_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl_val),
        .car_val  (car_val),
        .pos_half (pos_half),
        .duty     (duty)
    );

endmodule

// File: rtl/sine_pwm_mod_chk.sv
module sine_pwm_mod_chk #(
    parameter int CAR_W = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CAR_W-1:0]      car_peak,
    input logic [CAR_W-1:0]      car_val,
    input logic signed [CAR_W:0] ctrl,
    input logic                  period_start,
    input logic                  pos_half,
    input logic                  duty
);

    logic [CAR_W:0]        car_ext;
    logic signed [CAR_W:0] lim_pos, car_pos;

    assign car_ext = {1'b0, car_val};
    assign lim_pos = $signed({1'b0, car_peak});
    assign car_pos = $signed({1'b0, car_val});

    a_r2_car_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (car_ext == $past(car_ext)) || (car_ext == $past(car_ext) + 1'b1)
                 || (car_ext + 1'b1 == $past(car_ext)));

    a_r5_ctrl_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl <= lim_pos) && (ctrl >= -lim_pos));

    a_r6_half_held: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> $stable(pos_half));

    a_r7_pos_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_half && (ctrl > car_pos)) |=> duty);

    a_r8_neg_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_half && (ctrl < -car_pos)) |=> duty);

    a_r9_equal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((pos_half && (ctrl == car_pos)) || (!pos_half && (ctrl == -car_pos)))
        |=> $stable(duty));

endmodule

bind sine_pwm_mod sine_pwm_mod_chk #(.CAR_W(CAR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .car_peak     (car_peak),
    .car_val      (car_val),
    .ctrl         (ctrl_val),
    .period_start (period_start),
    .pos_half     (pos_half),
    .duty         (duty)
);

// File: tb/test_sine_pwm_mod.sv
module test_sine_pwm_mod;

    localparam int DATA_W = 12;
    localparam int GAIN_W = 8;
    localparam int CAR_W  = 11;
    localparam int DIV_W  = 8;

    logic                     clk;
    logic                     rst_n;
    logic signed [DATA_W-1:0] ref_smp;
    logic signed [DATA_W-1:0] meas_smp;
    logic [GAIN_W-1:0]        gain_a;
    logic [GAIN_W-1:0]        gain_b;
    logic [CAR_W-1:0]         car_peak;
    logic [DIV_W-1:0]         step_div;
    logic                     duty;
    logic                     pos_half;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    sine_pwm_mod i_sine_pwm_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_smp  (ref_smp),
        .meas_smp (meas_smp),
        .gain_a   (gain_a),
        .gain_b   (gain_b),
        .car_peak (car_peak),
        .step_div (step_div),
        .duty     (duty),
        .pos_half (pos_half)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // reference model built from the requirements
    int m_car, m_presc;
    bit m_rise, m_half, m_duty;

    function automatic longint exp_ctrl(longint r, longint m, longint ka, longint kb, longint pk);
        longint e, p1, p2;
        e  = r - m;                 // R3
        p1 = (e * ka) >>> 4;        // R4
        p2 = (p1 * kb) >>> 4;
        if (p2 > pk)  p2 = pk;      // R5
        if (p2 < -pk) p2 = -pk;
        return p2;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_car   <= 0;
            m_presc <= 0;
            m_rise  <= 1'b1;
            m_half  <= 1'b1;
            m_duty  <= 1'b0;
        end else begin
            int  n_car, n_presc, pk;
            bit  n_rise, n_half, n_duty, stp;
            longint c;
            pk     = int'(car_peak);
            n_car  = m_car;
            n_rise = m_rise;
            n_half = m_half;
            n_duty = m_duty;
            stp    = (m_presc >= int'(step_div));
            n_presc = stp ? 0 : m_presc + 1;
            if (stp) begin
                if (m_rise && m_car == 0) n_half = (ref_smp >= 0);
                if (m_rise) begin
                    if (m_car < pk) begin
                        n_car = m_car + 1;
                        if (n_car == pk) n_rise = 1'b0;
                    end else begin
                        n_rise = 1'b0;
                        if (m_car != 0) n_car = m_car - 1;
                    end
                end else begin
                    if (m_car != 0) begin
                        n_car = m_car - 1;
                        if (m_car == 1) n_rise = 1'b1;
                    end else begin
                        n_rise = 1'b1;
                    end
                end
            end
            c = exp_ctrl(ref_smp, meas_smp, gain_a, gain_b, pk);
            if (m_half) begin
                if (c > m_car) n_duty = 1'b1;
                else if (c < m_car) n_duty = 1'b0;
            end else begin
                if (c < -m_car) n_duty = 1'b1;
                else if (c > -m_car) n_duty = 1'b0;
            end
            m_car   <= n_car;
            m_presc <= n_presc;
            m_rise  <= n_rise;
            m_half  <= n_half;
            m_duty  <= n_duty;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start(input int pk, input int dv, input int r, input int m,
                         input int ka, input int kb);
        @(negedge clk);
        rst_n    = 1'b0;
        car_peak = CAR_W'(pk);
        step_div = DIV_W'(dv);
        ref_smp  = DATA_W'(r);
        meas_smp = DATA_W'(m);
        gain_a   = GAIN_W'(ka);
        gain_b   = GAIN_W'(kb);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n, output int bad_d, output int bad_h,
                       output int highs, output int lows_late);
        bad_d = 0; bad_h = 0; highs = 0; lows_late = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (duty !== m_duty)     bad_d++;
            if (pos_half !== m_half) bad_h++;
            if (duty) highs++;
            else if (i >= 2) lows_late++;
        end
    endtask

    int ref_highs;

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(duty == 1'b0, "R1", "duty in reset", int'(duty), 0);
        chk(pos_half == 1'b1, "R1", "pos_half in reset", int'(pos_half), 1);
    endtask

    task automatic t_pos_track;
        int bd, bh, hi, lo;
        start(20, 0, 12, 2, 16, 16);
        run(120, bd, bh, hi, lo);
        chk(bd == 0, "R7", "positive half duty mismatches", bd, 0);
        chk(bh == 0, "R6", "positive half flag mismatches", bh, 0);
        chk(hi > 0 && hi < 120, "R7", "duty modulates", hi, 60);
        ref_highs = hi;
    endtask

    task automatic t_gain;
        int bd, bh, hi, lo;
        start(20, 0, 5, -3, 40, 8);   // error 8, x2.5 = 20, x0.5 = 10
        run(120, bd, bh, hi, lo);
        chk(bd == 0, "R4", "gain chain duty mismatches", bd, 0);
        chk(hi == ref_highs, "R4", "high count vs unity gain run", hi, ref_highs);
        start(20, 0, 3, 0, 24, 16);   // 4.5 floors to 4
        run(80, bd, bh, hi, lo);
        chk(bd == 0, "R4", "fractional floor duty mismatches", bd, 0);
    endtask

    task automatic t_neg_track;
        int bd, bh, hi, lo;
        start(20, 0, -12, -2, 16, 16);
        run(120, bd, bh, hi, lo);
        chk(bd == 0, "R8", "negative half duty mismatches", bd, 0);
        chk(pos_half == 1'b0, "R6", "flag after negative reference", int'(pos_half), 0);
    endtask

    task automatic t_sat;
        int bd, bh, hi, lo;
        start(20, 0, 2000, -2000, 255, 255);
        run(100, bd, bh, hi, lo);
        chk(lo == 0, "R5", "positive saturation lows", lo, 0);
        chk(bd == 0, "R3", "full-scale error duty mismatches", bd, 0);
        start(20, 0, -2000, 2000, 255, 255);
        run(100, bd, bh, hi, lo);
        chk(lo == 0, "R5", "negative saturation lows", lo, 0);
    endtask

    task automatic t_equal;
        int bd, bh, hi, lo;
        start(20, 0, 20, 0, 16, 16);  // control equals the peak
        run(120, bd, bh, hi, lo);
        chk(lo == 0, "R9", "duty at equal peak", lo, 0);
        chk(bd == 0, "R9", "equality duty mismatches", bd, 0);
    endtask

    task automatic t_prescale;
        int bd, bh, hi, lo;
        start(5, 3, 2, 0, 16, 16);
        run(200, bd, bh, hi, lo);
        chk(bd == 0, "R2", "prescaled carrier duty mismatches", bd, 0);
        start(0, 0, 2, 0, 16, 16);
        run(20, bd, bh, hi, lo);
        chk(bd == 0 && bh == 0, "R2", "zero peak mismatches", bd + bh, 0);
    endtask

    task automatic t_half_hold;
        int guard;
        start(20, 0, 10, 0, 16, 16);
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!(m_rise && m_car == 10) && guard < 200);
        ref_smp = -12'sd10;
        @(negedge clk);
        chk(pos_half == 1'b1, "R6", "flag held mid-period", int'(pos_half), 1);
        repeat (40) @(negedge clk);
        chk(pos_half == 1'b0, "R6", "flag after boundary", int'(pos_half), 0);
    endtask

    task automatic t_latency;
        int guard;
        start(20, 0, 10, 0, 16, 16);
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!(!m_rise && m_car == 9) && guard < 200);
        chk(duty == 1'b0, "R10", "duty at first falling 9", int'(duty), 0);
        @(negedge clk);
        chk(duty == 1'b1, "R10", "duty one cycle later", int'(duty), 1);
    endtask

    initial begin
        rst_n = 1'b0;
        ref_smp = '0; meas_smp = '0; gain_a = 8'd16; gain_b = 8'd16;
        car_peak = 11'd20; step_div = '0;
        t_reset();
        t_pos_track();
        t_gain();
        t_neg_track();
        t_sat();
        t_equal();
        t_prescale();
        t_half_hold();
        t_latency();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule